// File: doc/BRIEF.md
# Quad-Slope Integrating Converter Sequencer

This block is the digital timing and counting core of an integrating analog-to-digital converter. It does not contain the integrator, the reference or the comparator. It drives a two-bit switch select that sets the integrator input to one of four sources: the auto-zero short, a zero input, the unknown signal, or the reference. It also watches a comparator line that goes high once the integrator output has returned to zero.

A conversion begins with an auto-zero interval, so the integrator can settle. Next comes a signal-integrate phase of fixed length. Last, the reference de-integrates the charge while a counter runs until the comparator trips. In quad-slope mode this sequence runs twice. The first pass integrates a shorted (zero) input, and its count is kept as the offset error. The second pass integrates the real input. The kept offset count is then subtracted digitally, giving a signed result. In dual-slope mode only the second pass runs, and the raw count is the result. If the comparator never trips, de-integration stops at twice the integrate length. The overrange flag is then raised and the result saturates.

FSM states: IDLE (integrator held in auto-zero, waiting for start), AZERO (auto-zero settle), INTEG (fixed-length integrate of the zero input on the offset pass, or of the signal on the signal pass), DEINT (reference de-integrate while counting). Transitions:
- IDLE→AZERO when start is seen.
- AZERO→INTEG when the auto-zero length has elapsed.
- INTEG→DEINT when the integrate length has elapsed.
- DEINT→AZERO at a trip or timeout on the offset pass.
- DEINT→IDLE at a trip or timeout on the signal pass. This transition loads the result and pulses done.

Top module: `qslope_seq`

## Requirements
- R1: After reset, sw_sel is 0 (auto-zero), done is 0, result is 0 and overrange is 0.
- R2: A start seen in IDLE begins a conversion whose length is fixed by the phase lengths and the counts. With the start edge counted as cycle 0, done is high after edge P*(AZ_CYCLES+INT_CYCLES) + sum of de-integrate counts. P is the number of passes: 2 in quad-slope mode and 1 in dual-slope mode. Each auto-zero interval drives sw_sel = 0 for AZ_CYCLES cycles.
- R3: Every signal pass drives sw_sel = 2 (signal) for exactly INT_CYCLES cycles, whatever the input.
- R4: De-integrate drives sw_sel = 3 (reference). Its count is the number of reference cycles, including the cycle in which the sampled comparator is first high, so the minimum count is 1.
- R5: In quad-slope mode, an offset pass comes first and drives sw_sel = 1 (zero) for INT_CYCLES cycles. The result is the signal count minus the offset count, as a signed two's-complement value, which may be negative.
- R6: In dual-slope mode, no zero-input pass runs and the result equals the raw de-integrate count.
- R7: If the comparator is still low at the end of de-integrate cycle 2*INT_CYCLES, overrange is set and the result is 2*INT_CYCLES. A trip in exactly that cycle gives that count with no overrange.
- R8: done is high for exactly one cycle, when result and overrange are updated. The result holds until the next update.
- R9: A start asserted while a conversion is in progress has no effect on its timing or result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Conversion request, sampled in IDLE only |
| cmp_zero | input | 1 | Comparator: high once the integrator has reached zero |
| sw_sel | output | 2 | Integrator input: 0 auto-zero, 1 zero input, 2 signal, 3 reference |
| result | output | CNT_W+1 | Signed conversion result |
| overrange | output | 1 | De-integrate timed out in the last conversion |
| done | output | 1 | One-cycle pulse when result updates |

## Verification
The bench builds two instances with INT_CYCLES = 32 and AZ_CYCLES = 4. One runs in quad-slope mode and the other in dual-slope mode, so both result paths are exercised side by side. The short integrate window puts the 64-cycle timeout within easy reach. It makes it possible to hit an exact trip on the last cycle, one step past it, and a signal below the offset that yields a negative result. With an offset model in the integrator, the offset cancellation can be compared against counts predicted from the same analog model.

// File: rtl/qs_pkg.sv
package qs_pkg;

    typedef enum logic [1:0] {
        SW_AZERO  = 2'd0,
        SW_ZERO   = 2'd1,
        SW_SIGNAL = 2'd2,
        SW_REF    = 2'd3
    } sw_sel_t;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_AZERO = 2'd1,
        ST_INTEG = 2'd2,
        ST_DEINT = 2'd3
    } seq_state_t;

endpackage

// File: rtl/qs_phase_timer.sv
module qs_phase_timer #(
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    output logic [TW-1:0] cnt
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + TW'(1);
        end
    end

endmodule

// File: rtl/qs_result_unit.sv
module qs_result_unit #(
    parameter int CNT_W     = 10,
    parameter int LIMIT     = 512,
    parameter bit QUAD_MODE = 1'b1,
    localparam int RES_W    = CNT_W + 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cap_off,
    input  logic                    fin,
    input  logic [CNT_W-1:0]        cnt_in,
    input  logic                    ovr_in,
    output logic signed [RES_W-1:0] result,
    output logic                    overrange,
    output logic                    done
);

    logic [CNT_W-1:0] off_cnt;
    logic             off_ovr;

    generate
        if (QUAD_MODE) begin : g_quad
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    off_cnt <= '0;
                    off_ovr <= 1'b0;
                end else if (cap_off) begin
                    off_cnt <= cnt_in;
                    off_ovr <= ovr_in;
                end
            end
        end else begin : g_dual
            assign off_cnt = '0;
            assign off_ovr = 1'b0;
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            result    <= '0;
            overrange <= 1'b0;
            done      <= 1'b0;
        end else begin
            done <= fin;
            if (fin) begin
                overrange <= ovr_in | off_ovr;
                if (ovr_in | off_ovr) begin
                    result <= $signed(RES_W'(LIMIT));
                end else begin
                    result <= $signed({1'b0, cnt_in}) - $signed({1'b0, off_cnt});
                end
            end
        end
    end

    a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r7_ovr_full_scale: assert property (@(posedge clk) disable iff (!rst_n)
        overrange |-> (result == $signed(RES_W'(LIMIT))));

endmodule

// File: rtl/qslope_seq.sv
module qslope_seq
    import qs_pkg::*;
#(
    parameter int INT_CYCLES = 256,
    parameter int AZ_CYCLES  = 16,
    parameter bit QUAD_MODE  = 1'b1,
    localparam int LIMIT     = 2 * INT_CYCLES,
    localparam int CNT_W     = $clog2(LIMIT + 1),
    localparam int RES_W     = CNT_W + 1,
    localparam int TMAX      = (AZ_CYCLES > LIMIT) ? AZ_CYCLES : LIMIT,
    localparam int TW        = $clog2(TMAX + 1)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start,
    input  logic                    cmp_zero,
    output logic [1:0]              sw_sel,
    output logic signed [RES_W-1:0] result,
    output logic                    overrange,
    output logic                    done
);

    localparam logic [TW-1:0] AZ_LAST  = TW'(AZ_CYCLES - 1);
    localparam logic [TW-1:0] INT_LAST = TW'(INT_CYCLES - 1);
    localparam logic [TW-1:0] LIM_LAST = TW'(LIMIT - 1);

    seq_state_t       state, nxt;
    logic             pass_sig;
    logic [TW-1:0]    tcnt;
    logic             clr;
    logic             cap_off;
    logic             fin;
    logic             deint_ovr;
    logic [CNT_W-1:0] deint_cnt;
    sw_sel_t          sel_q;

    assign deint_cnt = CNT_W'(tcnt) + CNT_W'(1);

    qs_phase_timer #(.TW(TW)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (clr),
        .cnt   (tcnt)
    );

    qs_result_unit #(
        .CNT_W     (CNT_W),
        .LIMIT     (LIMIT),
        .QUAD_MODE (QUAD_MODE)
    ) u_result (
        .clk       (clk),
        .rst_n     (rst_n),
        .cap_off   (cap_off),
        .fin       (fin),
        .cnt_in    (deint_cnt),
        .ovr_in    (deint_ovr),
        .result    (result),
        .overrange (overrange),
        .done      (done)
    );

    // state register and pass tracking
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            pass_sig <= 1'b0;
        end else begin
            state <= nxt;
            if (state == ST_IDLE && start) begin
                pass_sig <= !QUAD_MODE;
            end else if (cap_off) begin
                pass_sig <= 1'b1;
            end
        end
    end

    // next state and outputs
    always_comb begin
        nxt       = state;
        clr       = 1'b0;
        cap_off   = 1'b0;
        fin       = 1'b0;
        deint_ovr = 1'b0;
        sel_q     = SW_AZERO;
        unique case (state)
            ST_IDLE: begin
                clr = 1'b1;
                if (start) begin
                    nxt = ST_AZERO;
                end
            end
            ST_AZERO: begin
                if (tcnt == AZ_LAST) begin
                    nxt = ST_INTEG;
                    clr = 1'b1;
                end
            end
            ST_INTEG: begin
                sel_q = pass_sig ? SW_SIGNAL : SW_ZERO;
                if (tcnt == INT_LAST) begin
                    nxt = ST_DEINT;
                    clr = 1'b1;
                end
            end
            ST_DEINT: begin
                sel_q = SW_REF;
                if (cmp_zero || tcnt == LIM_LAST) begin
                    clr       = 1'b1;
                    deint_ovr = !cmp_zero;
                    if (!pass_sig) begin
                        cap_off = 1'b1;
                        nxt     = ST_AZERO;
                    end else begin
                        fin = 1'b1;
                        nxt = ST_IDLE;
                    end
                end
            end
            default: nxt = ST_IDLE;
        endcase
    end

    assign sw_sel = sel_q;

    a_r2_start_from_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && start) |=> (state == ST_AZERO));

    a_r9_busy_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_INTEG && start) |=> (state != ST_AZERO));

    a_r4_deint_window: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DEINT) |-> (tcnt < TW'(LIMIT)));

    a_r8_done_after_deint: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(state) == ST_DEINT));

    a_r8_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_DEINT) |=> $stable(result));

endmodule

// File: tb/sim_qslope_seq.sv
module sim_integ_model (
    input  logic       clk,
    input  logic [1:0] sel,
    input  int         vin,
    input  int         os,
    input  int         ref_lvl,
    output logic       cmp
);
    int acc;

    initial begin
        acc = 0;
        cmp = 1'b1;
    end

    always @(negedge clk) begin
        case (sel)
            2'd0:    acc = 0;
            2'd1:    acc = acc + os;
            2'd2:    acc = acc + vin + os;
            default: acc = acc + os - ref_lvl;
        endcase
        cmp = (acc <= 0);
    end
endmodule

module sim_qslope_seq;

    localparam int INT = 32;
    localparam int AZ  = 4;
    localparam int LIM = 2 * INT;
    localparam int REF = 40;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start0 = 1'b0, start1 = 1'b0;
    logic cmp0, cmp1;
    logic [1:0] sel0, sel1;
    logic signed [7:0] res0, res1;
    logic ovr0, ovr1, done0, done1;
    int vin = 0, os = 0;
    int checks = 0, errors = 0;

    always #4 clk = ~clk;

    qslope_seq #(.INT_CYCLES(INT), .AZ_CYCLES(AZ), .QUAD_MODE(1'b1)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start0), .cmp_zero(cmp0),
        .sw_sel(sel0), .result(res0), .overrange(ovr0), .done(done0));

    qslope_seq #(.INT_CYCLES(INT), .AZ_CYCLES(AZ), .QUAD_MODE(1'b0)) u1 (
        .clk(clk), .rst_n(rst_n), .start(start1), .cmp_zero(cmp1),
        .sw_sel(sel1), .result(res1), .overrange(ovr1), .done(done1));

    sim_integ_model m0 (.clk(clk), .sel(sel0), .vin(vin), .os(os), .ref_lvl(REF), .cmp(cmp0));
    sim_integ_model m1 (.clk(clk), .sel(sel1), .vin(vin), .os(os), .ref_lvl(REF), .cmp(cmp1));

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int deint_cnt(input int acc0, input int o, output bit ov);
        int a = acc0;
        ov = 1'b0;
        for (int k = 1; k <= LIM; k++) begin
            a = a + o - REF;
            if (a <= 0) return k;
        end
        ov = 1'b1;
        return LIM;
    endfunction

    task automatic run(input bit dual, input int v, input int o, input int ign_at);
        bit ovo, ovs, exp_ovr;
        int ko, ks, exp_res, exp_lat, n, c1, c2, c3;
        logic [1:0] s;
        logic signed [7:0] r;
        ovo = 1'b0;
        ko  = 0;
        if (!dual) ko = deint_cnt(INT * o, o, ovo);
        ks = deint_cnt(INT * (v + o), o, ovs);
        exp_ovr = ovo | ovs;
        exp_res = exp_ovr ? LIM : ks - ko;
        exp_lat = (dual ? 1 : 2) * (AZ + INT) + ko + ks + 1;
        @(negedge clk);
        vin = v;
        os  = o;
        if (dual) start1 = 1'b1; else start0 = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start0 = 1'b0;
        start1 = 1'b0;
        n = 1; c1 = 0; c2 = 0; c3 = 0;
        while (!(dual ? done1 : done0) && n < 2000) begin
            s = dual ? sel1 : sel0;
            if (s == 2'd1) c1++;
            if (s == 2'd2) c2++;
            if (s == 2'd3) c3++;
            if (n == ign_at) begin
                if (dual) start1 = 1'b1; else start0 = 1'b1;
            end else begin
                start0 = 1'b0;
                start1 = 1'b0;
            end
            @(posedge clk);
            n++;
            @(negedge clk);
        end
        start0 = 1'b0;
        start1 = 1'b0;
        r = dual ? res1 : res0;
        chk(n == exp_lat, "R2/R9 latency", n, exp_lat);
        chk(c2 == INT, "R3 signal cycles", c2, INT);
        chk(c1 == (dual ? 0 : INT), dual ? "R6 zero cycles" : "R5 zero cycles", c1, dual ? 0 : INT);
        chk(c3 == ko + ks, "R4 reference cycles", c3, ko + ks);
        chk(int'(r) == exp_res, dual ? "R6 result" : "R5 result", int'(r), exp_res);
        chk((dual ? ovr1 : ovr0) == exp_ovr, "R7 overrange", int'(dual ? ovr1 : ovr0), int'(exp_ovr));
        @(negedge clk);
        chk((dual ? done1 : done0) == 1'b0, "R8 done one cycle", int'(dual ? done1 : done0), 0);
        repeat (3) @(negedge clk);
        chk((dual ? res1 : res0) == r, "R8 result hold", int'(dual ? res1 : res0), int'(r));
    endtask

    initial begin
        #(8 * 150000);
        errors++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int seed;
        seed = $urandom(32'd4711);
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(sel0 == 2'd0 && sel1 == 2'd0, "R1 sw_sel", int'(sel0), 0);
        chk(!done0 && !done1, "R1 done", int'(done0), 0);
        chk(res0 == 0 && res1 == 0, "R1 result", int'(res0), 0);
        chk(!ovr0 && !ovr1, "R1 overrange", int'(ovr0), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        run(1'b0, 20, 3, 0);     // R5 typical
        run(1'b0, 0, 5, 3);      // R5 zero signal, R9 start in auto-zero
        run(1'b0, -3, 4, 12);    // R5 negative result, R9 start in integrate
        run(1'b0, 100, 2, 0);    // R7 overrange in quad mode
        run(1'b1, 20, 3, 40);    // R6 typical, R9 start in de-integrate
        run(1'b1, 80, 0, 0);     // R7 trip on the last allowed cycle
        run(1'b1, 81, 0, 0);     // R7 one step beyond: overrange
        run(1'b1, -5, 0, 0);     // R4 minimum count of 1

        for (int i = 0; i < 30; i++) begin
            int v, o, ig;
            bit d;
            v  = int'($urandom_range(0, 90)) - 5;
            o  = int'($urandom_range(0, 6));
            d  = 1'($urandom_range(0, 1));
            ig = ($urandom_range(0, 1) == 1) ? int'($urandom_range(2, 60)) : 0;
            run(d, v, o, ig);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule